// File: doc/BRIEF.md
# Status Ring Entry Producer

This block sits behind a command engine and turns each completed-command report into a fixed 26-word status entry written into a circular ring in memory. The engine pulses a start strobe when a command begins to execute, and later presents a report with the command number, a 2-bit result code and a 32-bit command-specific payload. The block combines these with the measured execution time and a free-running timestamp. It then writes the entry one 32-bit word per memory write, in ascending word address order.

The ring holds a parameterised number of entries. The producer keeps the write slot and a 4-bit pass counter, and stamps that counter into the top nibble of every entry's final word. A consumer can therefore tell fresh entries from stale ones by comparing the stamp (or only its low bit) with the value it expects, without reading the producer's pointer. The consumer reports its read slot. The producer holds off new reports when writing one more entry would reach that slot. A one-cycle interrupt pulse marks every completed entry.

A clock divider with a parameterised ratio produces a microsecond tick. That tick advances both the timestamp and the execution-time counter.

Top module: `status_ring_producer`

## Requirements
- R1: An entry is 26 words. Words 3 to 24 are written as zero, and bits 27:0 of word 25 are zero.
- R2: Word 0 bits 15:0 equal the command number of the accepted report.
- R3: Word 0 bits 25:16 hold the number of microsecond ticks since the last `exec_start`, sampled when the report is accepted. A tick occurs every CLKS_PER_US clocks. A start pulse clears the count in its own cycle, so time the report spends waiting does not restart it.
- R4: Word 0 bits 27:26 carry the result code: 0 success, 1 blocked queue or cache, 2 failed, 3 resource blocked. Bits 31:28 are zero.
- R5: Word 1 is the timestamp, the number of ticks since reset, sampled when the report is accepted.
- R6: Word 25 bits 31:28 carry the pass number modulo 16. Entries written in the first pass through the ring carry 1, and the value goes up by one at each wrap of the write slot, rolling from 15 to 0.
- R7: Word 2 carries the payload unchanged. For unblock reports, bit 0 is the error flag (targeted resource not in use) and bit 1 is the kind (0 single resource index, 1 whole cache).
- R8: Word k of the entry in slot s goes to word address s*26+k. Words go out in ascending order, one per cycle with `mem_wr_valid` and `mem_wr_ready` both high. Address and data hold steady while the write is stalled.
- R9: `irq` is high for exactly one cycle, in the cycle after the last word of an entry is accepted. The write slot advances at that same edge.
- R10: `rpt_ready` is low while an entry is being written, and also when the slot after the write slot equals `cons_rd_ptr`.
- R11: The execution-time field saturates at 1023 instead of wrapping.
- R12: After reset, `mem_wr_valid` and `irq` are low, and `rpt_ready` is high with `cons_rd_ptr` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_start | input | 1 | Pulse: a command starts executing |
| rpt_valid | input | 1 | Report present |
| rpt_ready | output | 1 | Report accepted when high together with valid |
| rpt_cmd_num | input | 16 | Command number being reported |
| rpt_result | input | 2 | Result code |
| rpt_payload | input | 32 | Command-specific payload word |
| cons_rd_ptr | input | PTR_W | Consumer's next slot to read |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory write accepted |
| mem_wr_addr | output | ADDR_W | Word address within the ring |
| mem_wr_data | output | 32 | Word to write |
| irq | output | 1 | One-cycle pulse per completed entry |

## Verification
The assertions check, on every cycle, that a stalled write holds its address and data, and that each word lands at the address implied by the slot and word position. They also check that reserved words and nibbles are zero, that the interrupt is a single cycle after the last word, and that reports are refused while busy or when the ring is full. The bench scenarios are needed for the field contents that depend on history: the command number and result, the tick-based execution time and its saturation, the timestamp, the payload, and the pass stamp rolling from 15 to 0 after many wraps. Irregular memory back-pressure and a frozen consumer drive those scenarios.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int ENTRY_WORDS = 26;
  localparam int WORD_W      = 32;
  localparam int CMD_W       = 16;
  localparam int EXEC_W      = 10;
  localparam int RES_W       = 2;
  localparam int LOOP_W      = 4;
  localparam int TS_W        = 32;

  typedef enum logic [RES_W-1:0] {
    RES_OK           = 2'd0,
    RES_BLOCKED      = 2'd1,
    RES_FAILED       = 2'd2,
    RES_RSRC_BLOCKED = 2'd3
  } exec_result_e;

  typedef struct packed {
    logic [3:0]          rsvd;
    exec_result_e        result;
    logic [EXEC_W-1:0]   exec_us;
    logic [CMD_W-1:0]    cmd_num;
  } hdr_word_t;
endpackage

// File: rtl/srp_us_timer.sv
module srp_us_timer #(
  parameter int CLKS_PER_US = 200,
  parameter int TS_W        = 32,
  parameter int EXEC_W      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_start,
  output logic [TS_W-1:0]   ts,
  output logic [EXEC_W-1:0] exec_us
);
  localparam int DIV_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [DIV_W-1:0]  DIV_LAST = DIV_W'(CLKS_PER_US - 1);
  localparam logic [EXEC_W-1:0] EXEC_MAX = '1;

  logic [DIV_W-1:0]  div_q, div_d;
  logic [TS_W-1:0]   ts_q, ts_d;
  logic [EXEC_W-1:0] exec_q, exec_d;
  logic              tick;

  always_comb begin
    tick  = (div_q == DIV_LAST);
    div_d = tick ? '0 : div_q + DIV_W'(1);
    ts_d  = tick ? ts_q + TS_W'(1) : ts_q;
    if (exec_start)
      exec_d = '0;
    else if (tick && (exec_q != EXEC_MAX))
      exec_d = exec_q + EXEC_W'(1);
    else
      exec_d = exec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      ts_q   <= '0;
      exec_q <= '0;
    end else begin
      div_q  <= div_d;
      ts_q   <= ts_d;
      exec_q <= exec_d;
    end
  end

  assign ts      = ts_q;
  assign exec_us = exec_q;
endmodule

// File: rtl/srp_ring_ptr.sv
module srp_ring_ptr #(
  parameter int RING_ENTRIES = 16,
  parameter int PTR_W        = 4,
  parameter int LOOP_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [PTR_W-1:0]  cons_rd_ptr,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic [LOOP_W-1:0] loop_stamp,
  output logic              full
);
  localparam logic [PTR_W-1:0] SLOT_LAST = PTR_W'(RING_ENTRIES - 1);

  logic [PTR_W-1:0]  wr_q, wr_d, wr_next;
  logic [LOOP_W-1:0] loop_q, loop_d;
  logic              at_last;

  always_comb begin
    at_last = (wr_q == SLOT_LAST);
    wr_next = at_last ? '0 : wr_q + PTR_W'(1);
    wr_d    = commit ? wr_next : wr_q;
    loop_d  = (commit && at_last) ? loop_q + LOOP_W'(1) : loop_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      loop_q <= '0;
    end else begin
      wr_q   <= wr_d;
      loop_q <= loop_d;
    end
  end

  assign wr_ptr     = wr_q;
  assign loop_stamp = loop_q + LOOP_W'(1);
  assign full       = (wr_next == cons_rd_ptr);
endmodule

// File: rtl/srp_entry_writer.sv
module srp_entry_writer #(
  parameter int WORDS  = 26,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 9,
  parameter int PTR_W  = 4,
  parameter int LOOP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] hdr_in,
  input  logic [WORD_W-1:0] ts_in,
  input  logic [WORD_W-1:0] pay_in,
  input  logic [LOOP_W-1:0] loop_stamp,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic              mem_wr_ready,
  output logic              busy,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [WORD_W-1:0] mem_wr_data,
  output logic              commit,
  output logic              irq
);
  localparam int WIDX_W = $clog2(WORDS);
  localparam logic [WIDX_W-1:0] IDX_HDR  = WIDX_W'(0);
  localparam logic [WIDX_W-1:0] IDX_TS   = WIDX_W'(1);
  localparam logic [WIDX_W-1:0] IDX_PAY  = WIDX_W'(2);
  localparam logic [WIDX_W-1:0] IDX_LAST = WIDX_W'(WORDS - 1);

  logic              busy_q, busy_d;
  logic [WIDX_W-1:0] widx_q, widx_d;
  logic              irq_q, irq_d;
  logic [WORD_W-1:0] hdr_q, ts_q, pay_q;
  logic              word_acc, last_acc;

  always_comb begin
    word_acc = busy_q && mem_wr_ready;
    last_acc = word_acc && (widx_q == IDX_LAST);
    busy_d   = busy_q;
    widx_d   = widx_q;
    if (start) begin
      busy_d = 1'b1;
      widx_d = '0;
    end else if (last_acc) begin
      busy_d = 1'b0;
      widx_d = '0;
    end else if (word_acc) begin
      widx_d = widx_q + WIDX_W'(1);
    end
    irq_d = last_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      widx_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      widx_q <= widx_d;
      irq_q  <= irq_d;
    end
  end

  // Datapath capture: enable only, no reset needed
  always_ff @(posedge clk) begin
    if (start) begin
      hdr_q <= hdr_in;
      ts_q  <= ts_in;
      pay_q <= pay_in;
    end
  end

  always_comb begin
    mem_wr_data = '0;
    if (widx_q == IDX_HDR)
      mem_wr_data = hdr_q;
    else if (widx_q == IDX_TS)
      mem_wr_data = ts_q;
    else if (widx_q == IDX_PAY)
      mem_wr_data = pay_q;
    else if (widx_q == IDX_LAST)
      mem_wr_data = {loop_stamp, {(WORD_W-LOOP_W){1'b0}}};
  end

  assign mem_wr_addr  = ADDR_W'(wr_ptr) * ADDR_W'(WORDS) + ADDR_W'(widx_q);
  assign busy         = busy_q;
  assign mem_wr_valid = busy_q;
  assign commit       = last_acc;
  assign irq          = irq_q;
endmodule

// File: rtl/status_ring_producer.sv
module status_ring_producer
  import srp_pkg::*;
#(
  parameter int RING_ENTRIES = 16,
  parameter int CLKS_PER_US  = 200,
  parameter int PTR_W        = (RING_ENTRIES > 1) ? $clog2(RING_ENTRIES) : 1,
  parameter int ADDR_W       = $clog2(RING_ENTRIES * ENTRY_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_start,
  input  logic              rpt_valid,
  output logic              rpt_ready,
  input  logic [CMD_W-1:0]  rpt_cmd_num,
  input  logic [RES_W-1:0]  rpt_result,
  input  logic [WORD_W-1:0] rpt_payload,
  input  logic [PTR_W-1:0]  cons_rd_ptr,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [WORD_W-1:0] mem_wr_data,
  output logic              irq
);
  logic [TS_W-1:0]   ts_now;
  logic [EXEC_W-1:0] exec_now;
  logic [PTR_W-1:0]  wr_ptr;
  logic [LOOP_W-1:0] loop_stamp;
  logic              ring_full, busy, commit, accept;
  hdr_word_t         hdr;

  srp_us_timer #(
    .CLKS_PER_US (CLKS_PER_US),
    .TS_W        (TS_W),
    .EXEC_W      (EXEC_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .exec_start (exec_start),
    .ts         (ts_now),
    .exec_us    (exec_now)
  );

  srp_ring_ptr #(
    .RING_ENTRIES (RING_ENTRIES),
    .PTR_W        (PTR_W),
    .LOOP_W       (LOOP_W)
  ) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit      (commit),
    .cons_rd_ptr (cons_rd_ptr),
    .wr_ptr      (wr_ptr),
    .loop_stamp  (loop_stamp),
    .full        (ring_full)
  );

  always_comb begin
    rpt_ready   = !busy && !ring_full;
    accept      = rpt_valid && rpt_ready;
    hdr.rsvd    = '0;
    hdr.result  = exec_result_e'(rpt_result);
    hdr.exec_us = exec_now;
    hdr.cmd_num = rpt_cmd_num;
  end

  srp_entry_writer #(
    .WORDS  (ENTRY_WORDS),
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W),
    .PTR_W  (PTR_W),
    .LOOP_W (LOOP_W)
  ) u_writer (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (accept),
    .hdr_in       (hdr),
    .ts_in        (ts_now),
    .pay_in       (rpt_payload),
    .loop_stamp   (loop_stamp),
    .wr_ptr       (wr_ptr),
    .mem_wr_ready (mem_wr_ready),
    .busy         (busy),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .commit       (commit),
    .irq          (irq)
  );
endmodule

// File: rtl/srp_checker.sv
module srp_checker #(
  parameter int WORDS  = 26,
  parameter int RING   = 16,
  parameter int PTR_W  = 4,
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rpt_ready,
  input logic [PTR_W-1:0]  cons_rd_ptr,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [31:0]       mem_wr_data,
  input logic              irq
);
  localparam int WIDX_W = $clog2(WORDS);
  localparam logic [WIDX_W-1:0] WLAST = WIDX_W'(WORDS - 1);
  localparam logic [PTR_W-1:0]  SLAST = PTR_W'(RING - 1);

  logic [WIDX_W-1:0] widx_c;
  logic [PTR_W-1:0]  slot_c, slot_nx;
  logic              acc;

  assign acc     = mem_wr_valid && mem_wr_ready;
  assign slot_nx = (slot_c == SLAST) ? '0 : slot_c + PTR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      widx_c <= '0;
      slot_c <= '0;
    end else if (acc) begin
      if (widx_c == WLAST) begin
        widx_c <= '0;
        slot_c <= slot_nx;
      end else begin
        widx_c <= widx_c + WIDX_W'(1);
      end
    end
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  // R8
  addr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> (mem_wr_addr == ADDR_W'(slot_c) * ADDR_W'(WORDS) + ADDR_W'(widx_c)));

  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && widx_c > WIDX_W'(2) && widx_c < WLAST) |-> (mem_wr_data == 32'd0));

  // R1
  last_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && widx_c == WLAST) |-> (mem_wr_data[27:0] == 28'd0));

  // R4
  hdr_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && widx_c == '0) |-> (mem_wr_data[31:28] == 4'd0));

  // R9
  irq_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && mem_wr_ready && widx_c == WLAST) |=> irq);

  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R10
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> !rpt_ready);

  // R10
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_ready |-> (slot_nx != cons_rd_ptr));
endmodule

bind status_ring_producer srp_checker #(
  .WORDS  (srp_pkg::ENTRY_WORDS),
  .RING   (RING_ENTRIES),
  .PTR_W  (PTR_W),
  .ADDR_W (ADDR_W)
) u_srp_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rpt_ready    (rpt_ready),
  .cons_rd_ptr  (cons_rd_ptr),
  .mem_wr_valid (mem_wr_valid),
  .mem_wr_ready (mem_wr_ready),
  .mem_wr_addr  (mem_wr_addr),
  .mem_wr_data  (mem_wr_data),
  .irq          (irq)
);

// File: tb/tb_status_ring_producer.sv
`timescale 1ns/1ps
module tb_status_ring_producer;
  localparam int RING   = 4;
  localparam int CPU    = 4;
  localparam int PTR_W  = 2;
  localparam int ADDR_W = 7;
  localparam int WORDS  = 26;

  logic clk = 1'b0;
  logic rst_n;
  logic exec_start, rpt_valid, rpt_ready;
  logic [15:0] rpt_cmd_num;
  logic [1:0]  rpt_result;
  logic [31:0] rpt_payload;
  logic [PTR_W-1:0] cons_rd_ptr;
  logic mem_wr_valid, mem_wr_ready, irq;
  logic [ADDR_W-1:0] mem_wr_addr;
  logic [31:0] mem_wr_data;

  always #2.5 clk = ~clk;

  status_ring_producer #(.RING_ENTRIES(RING), .CLKS_PER_US(CPU)) dut (
    .clk(clk), .rst_n(rst_n), .exec_start(exec_start),
    .rpt_valid(rpt_valid), .rpt_ready(rpt_ready),
    .rpt_cmd_num(rpt_cmd_num), .rpt_result(rpt_result), .rpt_payload(rpt_payload),
    .cons_rd_ptr(cons_rd_ptr), .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .irq(irq));

  int n_chk = 0, n_fail = 0;
  bit started = 0, done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, stepped on each rising edge
  int m_div, m_exec, m_widx, m_wrp, m_loop;
  logic [31:0] m_ts, m_hdr, m_tsl, m_pay;
  bit m_busy, m_irq, m_tick, m_full, m_irq_n;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_exec = 0; m_widx = 0; m_wrp = 0; m_loop = 0;
      m_ts = 0; m_busy = 0; m_irq = 0;
    end else begin
      m_tick  = (m_div == CPU - 1);
      m_full  = (((m_wrp + 1) % RING) == int'(cons_rd_ptr));
      m_irq_n = 0;
      if (rpt_valid && !m_busy && !m_full) begin
        m_hdr  = {4'b0, rpt_result, m_exec[9:0], rpt_cmd_num};
        m_tsl  = m_ts;
        m_pay  = rpt_payload;
        m_busy = 1; m_widx = 0;
      end else if (m_busy && mem_wr_ready) begin
        if (m_widx == WORDS - 1) begin
          m_busy = 0; m_widx = 0; m_irq_n = 1;
          if (m_wrp == RING - 1) begin m_wrp = 0; m_loop = (m_loop + 1) % 16; end
          else m_wrp++;
        end else m_widx++;
      end
      m_irq = m_irq_n;
      if (exec_start) m_exec = 0;
      else if (m_tick && m_exec < 1023) m_exec++;
      if (m_tick) begin m_ts = m_ts + 1; m_div = 0; end
      else m_div++;
    end
  end

  // Per-cycle compare, then drive memory ready and consumer pointer
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit cons_auto = 1;
  int cons_shadow = 0;
  logic [31:0] last_hdr;
  int prev_stamp = -1;
  bit seen_roll = 0;
  logic [31:0] e;

  always @(negedge clk) begin
    if (rst_n && started) begin
      chk("R10 rpt_ready", {31'b0, rpt_ready},
          {31'b0, !m_busy && (((m_wrp + 1) % RING) != int'(cons_rd_ptr))});
      chk("R8 mem_wr_valid", {31'b0, mem_wr_valid}, {31'b0, m_busy});
      chk("R9 irq", {31'b0, irq}, {31'b0, m_irq});
      if (m_busy && mem_wr_valid) begin
        chk("R8 address", {25'b0, mem_wr_addr}, 32'(m_wrp * WORDS + m_widx));
        if (m_widx == 0) begin
          chk("R2 command number", {16'b0, mem_wr_data[15:0]}, {16'b0, m_hdr[15:0]});
          chk("R3 execution time", {22'b0, mem_wr_data[25:16]}, {22'b0, m_hdr[25:16]});
          chk("R4 result and top nibble", {26'b0, mem_wr_data[31:26]}, {26'b0, m_hdr[31:26]});
        end else if (m_widx == 1) chk("R5 timestamp", mem_wr_data, m_tsl);
        else if (m_widx == 2) chk("R7 payload", mem_wr_data, m_pay);
        else if (m_widx == WORDS - 1) begin
          e = {4'((m_loop + 1) % 16), 28'b0};
          chk("R6 pass stamp", {28'b0, mem_wr_data[31:28]}, {28'b0, e[31:28]});
          chk("R1 last word low bits", {4'b0, mem_wr_data[27:0]}, 32'd0);
        end else chk("R1 reserved word", mem_wr_data, 32'd0);
      end
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_wr_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? lfsr[0] : 1'b0;
    if (rst_n && started && mem_wr_valid && mem_wr_ready) begin
      if (m_widx == 0) last_hdr = mem_wr_data;
      if (m_widx == WORDS - 1) begin
        if (prev_stamp == 15 && mem_wr_data[31:28] == 4'd0) seen_roll = 1;
        prev_stamp = int'(mem_wr_data[31:28]);
      end
    end
    if (rst_n && started && irq) begin
      cons_shadow = (cons_shadow + 1) % RING;
      if (cons_auto) cons_rd_ptr = PTR_W'(cons_shadow);
    end
  end

  task automatic send(input logic [15:0] n, input logic [1:0] r, input logic [31:0] p);
    rpt_cmd_num = n; rpt_result = r; rpt_payload = p; rpt_valid = 1'b1;
    while (!rpt_ready) @(negedge clk);
    @(negedge clk);
    rpt_valid = 1'b0;
  endtask

  task automatic pulse_start();
    exec_start = 1'b1;
    @(negedge clk);
    exec_start = 1'b0;
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
    while (mem_wr_valid || irq) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; exec_start = 1'b0; rpt_valid = 1'b0;
    rpt_cmd_num = '0; rpt_result = '0; rpt_payload = '0; cons_rd_ptr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    started = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 ready after reset", {31'b0, rpt_ready}, 32'd1);
    chk("R12 no write after reset", {31'b0, mem_wr_valid}, 32'd0);
    chk("R12 no irq after reset", {31'b0, irq}, 32'd0);

    // Plain reports, all result codes, unblock payloads (R2 R4 R7)
    pulse_start();
    repeat (10) @(negedge clk);
    send(16'h0001, 2'd0, 32'h0000_0002);
    send(16'h1234, 2'd1, 32'h0000_0000);
    pulse_start();
    send(16'hBEEF, 2'd2, 32'h0000_0001);
    send(16'hFFFF, 2'd3, 32'h0000_0003);
    drain();

    // Irregular memory back-pressure (R8), start pulse while report waits (R3)
    rdy_mode = 1;
    pulse_start();
    repeat (37) @(negedge clk);
    send(16'h0042, 2'd0, 32'hA5A5_5A5A);
    pulse_start();
    send(16'h0043, 2'd1, 32'h0000_0002);
    send(16'h0044, 2'd0, 32'h8000_0001);
    drain();

    // Frozen consumer: ring fills after RING-1 entries (R10)
    rdy_mode = 0;
    cons_auto = 0;
    for (int i = 0; i < RING - 1; i++) send(16'(16'h0100 + i), 2'd0, 32'(i));
    drain();
    rpt_cmd_num = 16'h0200; rpt_result = 2'd0; rpt_payload = 32'h1; rpt_valid = 1'b1;
    repeat (60) @(negedge clk);
    chk("R10 ready low while ring full", {31'b0, rpt_ready}, 32'd0);
    chk("R10 no write while ring full", {31'b0, mem_wr_valid}, 32'd0);
    cons_rd_ptr = PTR_W'(cons_shadow);
    cons_auto = 1;
    while (!rpt_ready) @(negedge clk);
    @(negedge clk);
    rpt_valid = 1'b0;
    drain();

    // Long execution: field saturates (R11)
    pulse_start();
    repeat (CPU * 1100) @(negedge clk);
    send(16'h0300, 2'd0, 32'h0);
    drain();
    chk("R11 execution time saturated", {22'b0, last_hdr[25:16]}, 32'd1023);

    // Many passes around the ring: stamp rolls 15 to 0 (R6)
    for (int i = 0; i < 70; i++) begin
      rdy_mode = (i % 3 == 0) ? 1 : 0;
      send(16'(i), 2'(i), 32'(i * 7));
    end
    drain();
    chk("R6 pass stamp rolled from 15 to 0", {31'b0, seen_roll}, 32'd1);

    finish_up();
  end
endmodule